// File: doc/BRIEF.md
# Page Write Buffer and Programming Sequencer

This block sits between a serial slave front end and a 256-byte non-volatile array. Once the front end has decoded a write, it hands over the word address and then one strobe per received data byte. The block keeps those bytes in an eight-slot staging buffer, and the low three bits of the word address select the slot. When the transfer ends with a STOP, the block opens a programming cycle of fixed length and copies the staged bytes into the array through a simple write port. If the transfer ends with a repeated START instead, everything staged is thrown away.

A STOP after a single data byte gives one array write at the loaded address. A STOP after two or more bytes commits the page. Only the slots that were written are copied, each to its own location inside the aligned eight-byte page. The write index only wraps inside the page, so any bytes beyond eight overwrite the earliest ones. While a cycle is in progress the block raises busy, and the front end is expected to refuse new traffic. The block also keeps a saturating count of completed programming cycles so that wear can be watched.

Top module: `page_prog_sequencer`

## Requirements
- R1: When reset is high, busy goes low, no array write strobe is issued and the wear count goes to zero.
- R2: The n-th data byte after an address load (n counted from 0) goes to slot (addr[2:0] + n) mod 8. The page base addr[7:3] is never changed. The slot is committed to array address {addr[7:3], slot}.
- R3: With more than eight data bytes, the slot index wraps and overwrites earlier slots. Each location receives the last byte written to its slot.
- R4: A STOP after exactly one data byte gives exactly one array write, at the loaded address. It occurs in the first cycle busy is high.
- R5: A STOP after two or more data bytes gives one array write per written slot and none for unwritten slots. The writes go in ascending slot order, within the first eight busy cycles.
- R6: A repeated START while idle discards the staged bytes. No busy and no array write follow, and a later STOP with no new bytes starts nothing.
- R7: A STOP with no data bytes staged starts no programming cycle.
- R8: An accepted STOP raises busy on the next clock. Busy then stays high for exactly PROG_CYCLES cycles.
- R9: While busy, address loads, data bytes, STOP and repeated START are all ignored. They change neither the cycle length nor what is written.
- R10: The wear count rises by one as each programming cycle completes and holds at its all-ones value.
- R11: The array write strobe is only ever high while busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Word address strobe from the front end |
| addr_in | input | 8 | Word address |
| byte_vld | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte |
| stop_evt | input | 1 | STOP condition seen |
| rstart_evt | input | 1 | Repeated START seen |
| busy | output | 1 | Programming cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 8 | Array write address |
| mem_wdata | output | 8 | Array write data |
| wear_count | output | WEAR_W | Saturating count of completed cycles |

## Verification
Some rules are checked by the assertions on every clock: writes happen only while busy, each busy window has the exact length, a STOP either launches a cycle or is refused depending on whether bytes are staged, a repeated START never starts a cycle, and the wear count steps once per completion. Other properties need a whole transaction to show up: which array locations change and to what values, the slot wrap inside a page, the write order, and the fact that traffic during busy is ignored. The bench shows these by keeping its own image of the array and comparing it after every transaction.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int SLOT_W = 3;
    localparam int NSLOT  = 1 << SLOT_W;
    localparam int BASE_W = ADDR_W - SLOT_W;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_COMMIT = 2'd1,
        SEQ_HOLD   = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        FILL_NONE = 2'd0,
        FILL_ONE  = 2'd1,
        FILL_MANY = 2'd2
    } fill_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } arr_wr_t;

    function automatic fill_e fill_step(input fill_e cur);
        return (cur == FILL_NONE) ? FILL_ONE : FILL_MANY;
    endfunction

    function automatic logic [ADDR_W-1:0] page_addr(input logic [BASE_W-1:0] base,
                                                   input logic [SLOT_W-1:0] slot);
        return {base, slot};
    endfunction

endpackage

// File: rtl/pps_page_buffer.sv
module pps_page_buffer
    import pps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              discard,
    input  logic              release_buf,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_in,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [BASE_W-1:0] page_base,
    output logic [SLOT_W-1:0] first_slot,
    output logic [NSLOT-1:0]  slot_valid,
    output fill_e             fill,
    output logic [DATA_W-1:0] rd_data
);

    logic [SLOT_W-1:0]             wr_idx;
    logic [NSLOT-1:0][DATA_W-1:0]  slot_data;
    logic                          take_byte;

    assign take_byte = accept && !discard && !addr_load && byte_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx     <= '0;
            page_base  <= '0;
            first_slot <= '0;
            slot_valid <= '0;
            fill       <= FILL_NONE;
        end else if (release_buf) begin
            slot_valid <= '0;
            fill       <= FILL_NONE;
        end else if (accept) begin
            if (discard) begin
                slot_valid <= '0;
                fill       <= FILL_NONE;
            end else if (addr_load) begin
                page_base  <= addr_in[ADDR_W-1:SLOT_W];
                wr_idx     <= addr_in[SLOT_W-1:0];
                first_slot <= addr_in[SLOT_W-1:0];
                slot_valid <= '0;
                fill       <= FILL_NONE;
            end else if (byte_vld) begin
                slot_valid[wr_idx] <= 1'b1;
                wr_idx             <= wr_idx + 1'b1;
                fill               <= fill_step(fill);
            end
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (take_byte && (wr_idx == SLOT_W'(g))) begin
                q <= byte_in;
            end
        end
        assign slot_data[g] = q;
    end

    assign rd_data = slot_data[rd_slot];

endmodule

// File: rtl/pps_prog_seq.sv
module pps_prog_seq
    import pps_pkg::*;
#(
    parameter int PROG_CYCLES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_evt,
    input  logic              rstart_evt,
    input  fill_e             fill,
    input  logic [SLOT_W-1:0] first_slot,
    input  logic [NSLOT-1:0]  slot_valid,
    input  logic [BASE_W-1:0] page_base,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic [SLOT_W-1:0] rd_slot,
    output arr_wr_t           wr
);

    localparam int TMR_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

    seq_state_e        state;
    logic [TMR_W-1:0]  tmr;
    logic [SLOT_W-1:0] slot;
    logic              single;
    logic              go;

    assign go = stop_evt && !rstart_evt && (state == SEQ_IDLE) && (fill != FILL_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            tmr    <= '0;
            slot   <= '0;
            single <= 1'b0;
        end else if (state == SEQ_IDLE) begin
            if (go) begin
                state  <= SEQ_COMMIT;
                tmr    <= TMR_W'(PROG_CYCLES - 1);
                single <= (fill == FILL_ONE);
                slot   <= (fill == FILL_ONE) ? first_slot : '0;
            end
        end else if (tmr == '0) begin
            state <= SEQ_IDLE;
        end else begin
            tmr <= tmr - 1'b1;
            if (state == SEQ_COMMIT) begin
                slot <= slot + 1'b1;
                if (single || slot == SLOT_W'(NSLOT - 1)) begin
                    state <= SEQ_HOLD;
                end
            end
        end
    end

    assign busy    = (state != SEQ_IDLE);
    assign done    = busy && (tmr == '0);
    assign rd_slot = slot;

    always_comb begin
        wr.we   = (state == SEQ_COMMIT) && slot_valid[slot];
        wr.addr = page_addr(page_base, slot);
        wr.data = rd_data;
    end

endmodule

// File: rtl/pps_wear_ctr.sv
module pps_wear_ctr #(
    parameter int WEAR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bump,
    output logic [WEAR_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (bump && !(&count)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/page_prog_sequencer.sv
module page_prog_sequencer
    import pps_pkg::*;
#(
    parameter int PROG_CYCLES = 4096,
    parameter int WEAR_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load,
    input  logic [7:0]        addr_in,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              stop_evt,
    input  logic              rstart_evt,
    output logic              busy,
    output logic              mem_we,
    output logic [7:0]        mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [WEAR_W-1:0] wear_count
);

    logic [BASE_W-1:0] page_base;
    logic [SLOT_W-1:0] first_slot;
    logic [NSLOT-1:0]  slot_valid;
    fill_e             fill;
    logic [DATA_W-1:0] rd_data;
    logic [SLOT_W-1:0] rd_slot;
    logic              done;
    arr_wr_t           wr;

    pps_page_buffer u_buf (
        .clk         (clk),
        .rst         (rst),
        .accept      (!busy),
        .discard     (rstart_evt),
        .release_buf (done),
        .addr_load   (addr_load),
        .addr_in     (addr_in),
        .byte_vld    (byte_vld),
        .byte_in     (byte_in),
        .rd_slot     (rd_slot),
        .page_base   (page_base),
        .first_slot  (first_slot),
        .slot_valid  (slot_valid),
        .fill        (fill),
        .rd_data     (rd_data)
    );

    pps_prog_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .stop_evt   (stop_evt),
        .rstart_evt (rstart_evt),
        .fill       (fill),
        .first_slot (first_slot),
        .slot_valid (slot_valid),
        .page_base  (page_base),
        .rd_data    (rd_data),
        .busy       (busy),
        .done       (done),
        .rd_slot    (rd_slot),
        .wr         (wr)
    );

    pps_wear_ctr #(.WEAR_W(WEAR_W)) u_wear (
        .clk   (clk),
        .rst   (rst),
        .bump  (done),
        .count (wear_count)
    );

    assign mem_we    = wr.we;
    assign mem_addr  = wr.addr;
    assign mem_wdata = wr.data;

endmodule

// File: rtl/pps_checker.sv
module pps_checker
    import pps_pkg::*;
#(
    parameter int PROG_CYCLES = 4096,
    parameter int WEAR_W      = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              stop_evt,
    input logic              rstart_evt,
    input logic              busy,
    input logic              mem_we,
    input logic [WEAR_W-1:0] wear_count,
    input fill_e             fill
);

    int unsigned span;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            span <= 0;
        end else begin
            span <= span + 1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!busy && wear_count == '0)); // R1

    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy); // R11

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (span == PROG_CYCLES)); // R8

    AST_STOP_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (stop_evt && !rstart_evt && !busy && fill != FILL_NONE) |=> busy); // R8

    AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (rst)
        (stop_evt && !busy && fill == FILL_NONE) |=> !busy); // R7

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rstart_evt && !busy) |=> (!busy && !mem_we)); // R6

    AST_WEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ((wear_count == $past(wear_count) + 1'b1) || (&$past(wear_count)))); // R10

    AST_WEAR_STILL: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(wear_count) || $fell(busy)); // R10

endmodule

bind page_prog_sequencer pps_checker #(
    .PROG_CYCLES (PROG_CYCLES),
    .WEAR_W      (WEAR_W)
) u_pps_chk (
    .clk        (clk),
    .rst        (rst),
    .stop_evt   (stop_evt),
    .rstart_evt (rstart_evt),
    .busy       (busy),
    .mem_we     (mem_we),
    .wear_count (wear_count),
    .fill       (fill)
);

// File: tb/page_prog_sequencer_tb_top.sv
module page_prog_sequencer_tb_top;

    localparam int P  = 16;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          addr_load = 1'b0;
    logic [7:0]    addr_in = '0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_in = '0;
    logic          stop_evt = 1'b0;
    logic          rstart_evt = 1'b0;
    logic          busy;
    logic          mem_we;
    logic [7:0]    mem_addr;
    logic [7:0]    mem_wdata;
    logic [WW-1:0] wear_count;

    always #2 clk = ~clk;

    page_prog_sequencer #(.PROG_CYCLES(P), .WEAR_W(WW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .addr_load  (addr_load),
        .addr_in    (addr_in),
        .byte_vld   (byte_vld),
        .byte_in    (byte_in),
        .stop_evt   (stop_evt),
        .rstart_evt (rstart_evt),
        .busy       (busy),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .wear_count (wear_count)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    int         completions = 0;
    logic [7:0] exp_mem [256];
    logic [7:0] act_mem [256];
    int         wr_total = 0;
    int         ord_err = 0;
    int         first_pos = -1;
    int         bpos = 0;
    bit         have_wr = 1'b0;
    logic [7:0] last_a = '0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            exp_mem[i] = '0;
            act_mem[i] = '0;
        end
    end

    always @(negedge clk) begin
        if (mem_we) begin
            act_mem[mem_addr] = mem_wdata;
            wr_total++;
            if (have_wr && mem_addr <= last_a) ord_err++;
            if (!have_wr) first_pos = bpos;
            have_wr = 1'b1;
            last_a  = mem_addr;
        end
        if (busy) begin
            bpos++;
        end else begin
            bpos    = 0;
            have_wr = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int mem_mismatches();
        int m = 0;
        for (int i = 0; i < 256; i++) begin
            if (exp_mem[i] !== act_mem[i]) m++;
        end
        return m;
    endfunction

    function automatic int exp_wear(input int c);
        return (c > (1 << WW) - 1) ? (1 << WW) - 1 : c;
    endfunction

    task automatic lone_stop(input string req);
        int w0 = wr_total;
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0; #1;
        chk(busy == 1'b0, req, busy, 0);
        repeat (2) @(negedge clk);
        #1;
        chk(wr_total == w0, req, wr_total - w0, 0);
    endtask

    task automatic run_txn(input logic [7:0] a, input int nb, input bit use_stop, input bit noise);
        logic [7:0] mb [8];
        logic [7:0] mm = '0;
        logic [2:0] s;
        int w0 = wr_total;
        int o0 = ord_err;
        int cyc;
        int nexp;
        bit exp_busy;
        string rq;
        @(negedge clk); addr_load = 1'b1; addr_in = a;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            addr_load = 1'b0;
            byte_vld  = 1'b1;
            byte_in   = 8'($urandom);
            s         = 3'(a[2:0] + 3'(i));
            mb[s]     = byte_in;
            mm[s]     = 1'b1;
        end
        @(negedge clk);
        addr_load = 1'b0; byte_vld = 1'b0;
        if (use_stop) stop_evt = 1'b1; else rstart_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0; rstart_evt = 1'b0; #1;
        exp_busy = use_stop && (nb > 0);
        rq = !use_stop ? "R6" : (nb == 0 ? "R7" : "R8");
        chk(busy == exp_busy, rq, busy, exp_busy);
        if (exp_busy) begin
            cyc = 1;
            forever begin
                if (noise) begin
                    {addr_load, byte_vld, stop_evt, rstart_evt} = 4'($urandom);
                    addr_in = 8'($urandom);
                    byte_in = 8'($urandom);
                end
                @(negedge clk); #1;
                {addr_load, byte_vld, stop_evt, rstart_evt} = 4'b0;
                if (!busy) break;
                cyc++;
            end
            for (int k = 0; k < 8; k++) begin
                if (mm[k]) exp_mem[{a[7:3], 3'(k)}] = mb[k];
            end
            completions++;
            nexp = $countones(mm);
            chk(cyc == P, noise ? "R9" : "R8", cyc, P);
            chk(wr_total - w0 == nexp, nb == 1 ? "R4" : "R5", wr_total - w0, nexp);
            chk(ord_err == o0, "R5", ord_err - o0, 0);
            if (nb == 1) chk(first_pos == 0, "R4", first_pos, 0);
            chk(mem_mismatches() == 0, noise ? "R9" : (nb > 8 ? "R3" : "R2"), mem_mismatches(), 0);
            chk(int'(wear_count) == exp_wear(completions), "R10", wear_count, exp_wear(completions));
        end else begin
            repeat (3) @(negedge clk);
            #1;
            chk(wr_total == w0, rq, wr_total - w0, 0);
            chk(mem_mismatches() == 0, rq, mem_mismatches(), 0);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd24601));
        repeat (3) @(negedge clk);
        #1;
        chk(busy == 1'b0, "R1", busy, 0);
        chk(mem_we == 1'b0, "R1", mem_we, 0);
        chk(wear_count == '0, "R1", wear_count, 0);
        @(negedge clk); rst = 1'b0;

        run_txn(8'h40, 1, 1'b1, 1'b0);   // R4 single byte
        run_txn(8'h15, 3, 1'b1, 1'b0);   // R5 page
        run_txn(8'h2F, 3, 1'b1, 1'b0);   // R2 wrap from slot 7 to 0 inside page
        run_txn(8'hA3, 9, 1'b1, 1'b0);   // R3 rollover
        run_txn(8'h60, 13, 1'b1, 1'b0);  // R3 deep rollover
        run_txn(8'h70, 5, 1'b0, 1'b0);   // R6 abort
        lone_stop("R6");
        run_txn(8'h80, 0, 1'b1, 1'b0);   // R7 empty stop
        run_txn(8'hFF, 2, 1'b1, 1'b1);   // R9 traffic during busy
        lone_stop("R9");

        for (int t = 0; t < 40; t++) begin
            run_txn(8'($urandom), int'($urandom % 12), ($urandom % 5) != 0, 1'($urandom));
        end

        chk(int'(wear_count) == exp_wear(completions), "R10", wear_count, exp_wear(completions));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule